// File: doc/BRIEF.md
# Flash Write-Permission Gate

This block keeps the write-protection state of a serial flash device and decides which decoded modifying commands reach the memory array. A serial front-end shifts in each instruction and hands over one event when chip select rises. The event carries the opcode, the address, the first data byte, the number of complete bus cycles seen, and a flag for a trailing partial cycle. The gate checks each event against the write-enable latch, the pairing rule for status writes, the auto-increment program state and the busy flag. An accepted command becomes a single-cycle operation strobe. The strobe carries a kind code, a region address and a data byte.

Programming and erasing need a prior write-enable instruction. A status write needs the enable-status-write opcode as the instruction just before it. Erase addresses are rounded down to their region base. An auto-increment program stream starts with one full-address command and is then continued by short opcode-plus-data commands, each programming the next address. While an issued operation is unacknowledged, the gate drops further modifying commands.

Top module: `flash_wr_gate`

## Requirements
- R1: After reset, `wel`, `busy` and `aai_active` are 0 and `op_strobe` is low.
- R2: Opcode 06h with exactly 1 complete cycle sets `wel` on the following clock edge. Opcode 04h with 1 cycle clears it there.
- R3: Opcodes 02h (5 cycles), AFh (5 cycles, outside auto-increment mode), 20h (4 cycles), 52h/D8h (4 cycles) and 60h/C7h (1 cycle) raise a strobe only while `wel` is 1. Otherwise they are dropped, and `wel` stays as it was.
- R4: An accepted command pulses `op_strobe` for one cycle, on the clock edge that samples the event. `op_kind` is 0 for program, 1 for sector erase, 2 for block erase, 3 for chip erase and 4 for status write. A byte program carries the full address and the data byte.
- R5: Sector erase clears address bits 11..0. Block erase clears bits 14..0. Chip erase and status write report address 0.
- R6: Opcode 01h with 2 cycles issues kind 4 with its data byte only if the previous complete instruction was 50h. It does not need `wel`. Any other complete instruction in between cancels the pairing.
- R7: An accepted AFh with 5 cycles programs its address and sets `aai_active`. While the mode is active, each AFh with exactly 2 cycles programs the previous address plus one.
- R8: While `aai_active`, any complete instruction other than AFh or 05h ends the mode and clears `wel`. Opcode 05h leaves the mode running. If the ending opcode is 06h, the latch is set again.
- R9: Programming the top address (all AW bits 1) in auto-increment mode ends the mode and clears `wel` on the same edge.
- R10: An event with the partial flag set, or with a cycle count other than the one its opcode requires, has no effect. This includes the status-write pairing.
- R11: A strobe sets `busy` until `op_ack`. While `busy` is 1, every command that would strobe is dropped, including an auto-increment step, which stays pending in the mode.
- R12: Acknowledging a non-auto-increment operation clears `wel`. Acknowledging an auto-increment program keeps it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle event at chip-select rise |
| cmd_op | input | 8 | Opcode of the event |
| cmd_addr | input | AW | Address of the event |
| cmd_data | input | 8 | First data byte of the event |
| cmd_cycles | input | 3 | Complete bus cycles received, saturating at 7 |
| cmd_partial | input | 1 | A trailing incomplete cycle was seen |
| op_ack | input | 1 | Memory side finished the pending operation |
| op_strobe | output | 1 | One-cycle operation request |
| op_kind | output | 3 | Operation kind code |
| op_addr | output | AW | Region or byte address |
| op_data | output | 8 | Program or status data |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Operation awaiting acknowledge |
| aai_active | output | 1 | Auto-increment program mode active |

## Verification
The bench sweeps all 256 opcodes with a cycle count that fits only a few of them, while the latch is clear. A gate that ignored the latch, or one that matched on the opcode without checking length, would strobe there. It sweeps erase addresses across region boundaries. A wrong mask width would leak low bits or drop a region bit. The auto-increment checks run a stream up to the top address, interleave status reads, and send a step while busy. An off-by-one counter, a mode that ends on a status read, or a mode that runs past the top address would show up as a wrong address or a latch still set. Status-write pairing is checked with a status read in between and with an incomplete event in between. A pairing that survived a read would wrongly strobe. One cancelled by a discarded event would wrongly stay silent.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;

   localparam logic [7:0] OPC_WREN  = 8'h06;
   localparam logic [7:0] OPC_WRDI  = 8'h04;
   localparam logic [7:0] OPC_EWSR  = 8'h50;
   localparam logic [7:0] OPC_WRSR  = 8'h01;
   localparam logic [7:0] OPC_PROG  = 8'h02;
   localparam logic [7:0] OPC_AAI   = 8'hAF;
   localparam logic [7:0] OPC_SECT  = 8'h20;
   localparam logic [7:0] OPC_BLK_A = 8'h52;
   localparam logic [7:0] OPC_BLK_B = 8'hD8;
   localparam logic [7:0] OPC_CHP_A = 8'h60;
   localparam logic [7:0] OPC_CHP_B = 8'hC7;
   localparam logic [7:0] OPC_RDSR  = 8'h05;

   typedef enum logic [3:0] {
      C_WREN, C_WRDI, C_EWSR, C_WRSR, C_PROG, C_AAI1, C_AAIN,
      C_SECT, C_BLK, C_CHIP, C_RDSR, C_OTHER
   } cmd_cls_e;

   typedef enum logic [2:0] {
      K_PROG = 3'd0, K_SECT = 3'd1, K_BLK = 3'd2, K_CHIP = 3'd3, K_WRSR = 3'd4
   } op_kind_e;

endpackage

// File: rtl/fwg_classify.sv
module fwg_classify
   import flash_gate_pkg::*;
(
   input  logic [7:0] op,
   input  logic [2:0] cycles,
   input  logic       partial,
   input  logic       aai_on,
   output cmd_cls_e   cls,
   output logic       complete
);
   logic [2:0] need;
   logic       any_len;

   always_comb begin
      cls     = C_OTHER;
      need    = 3'd1;
      any_len = 1'b0;
      case (op)
         OPC_WREN:             begin cls = C_WREN; need = 3'd1; end
         OPC_WRDI:             begin cls = C_WRDI; need = 3'd1; end
         OPC_EWSR:             begin cls = C_EWSR; need = 3'd1; end
         OPC_WRSR:             begin cls = C_WRSR; need = 3'd2; end
         OPC_PROG:             begin cls = C_PROG; need = 3'd5; end
         OPC_AAI: begin
            cls  = aai_on ? C_AAIN : C_AAI1;
            need = aai_on ? 3'd2 : 3'd5;
         end
         OPC_SECT:             begin cls = C_SECT; need = 3'd4; end
         OPC_BLK_A, OPC_BLK_B: begin cls = C_BLK;  need = 3'd4; end
         OPC_CHP_A, OPC_CHP_B: begin cls = C_CHIP; need = 3'd1; end
         OPC_RDSR:             begin cls = C_RDSR; any_len = 1'b1; end
         default:              begin cls = C_OTHER; any_len = 1'b1; end
      endcase
      if (any_len) complete = !partial && (cycles != 3'd0);
      else         complete = !partial && (cycles == need);
   end
endmodule

// File: rtl/fwg_guard.sv
module fwg_guard
   import flash_gate_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ev,
   input  cmd_cls_e cls,
   input  logic     issue,
   input  logic     issue_aai,
   input  logic     aai_fin,
   input  logic     ack,
   output logic     wel,
   output logic     ewsr_arm,
   output logic     busy
);
   logic busy_aai;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wel      <= 1'b0;
         ewsr_arm <= 1'b0;
         busy     <= 1'b0;
         busy_aai <= 1'b0;
      end else begin
         if (ack && busy && !busy_aai) wel <= 1'b0;
         if (aai_fin)                  wel <= 1'b0;
         if (ev && cls == C_WREN)      wel <= 1'b1;
         if (ev && cls == C_WRDI)      wel <= 1'b0;
         if (ev)                       ewsr_arm <= (cls == C_EWSR);
         if (issue) begin
            busy     <= 1'b1;
            busy_aai <= issue_aai;
         end else if (ack) begin
            busy     <= 1'b0;
         end
      end
   end

   assert_wren_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && cls == C_WREN) |=> wel);
   assert_wrdi_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && cls == C_WRDI) |=> !wel);
   assert_ack_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !issue) |=> !busy);
endmodule

// File: rtl/fwg_aai_seq.sv
module fwg_aai_seq #(
   parameter int AW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic          step,
   input  logic          stop,
   output logic          on,
   output logic [AW-1:0] next_addr,
   output logic          fin
);
   localparam logic [AW-1:0] TOP = {AW{1'b1}};

   assign fin = (start && start_addr == TOP) || (step && next_addr == TOP) || (stop && on);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         on        <= 1'b0;
         next_addr <= '0;
      end else begin
         if (start) begin
            on        <= (start_addr != TOP);
            next_addr <= start_addr + 1'b1;
         end else if (step) begin
            if (next_addr == TOP) on <= 1'b0;
            else                  next_addr <= next_addr + 1'b1;
         end
         if (stop) on <= 1'b0;
      end
   end

   assert_step_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && next_addr != TOP) |=> (on && next_addr == $past(next_addr) + 1'b1));
   assert_top_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (step && next_addr == TOP) |=> !on);
endmodule

// File: rtl/flash_wr_gate.sv
module flash_wr_gate
   import flash_gate_pkg::*;
#(
   parameter int AW       = 17,
   parameter int SECT_LSB = 12,
   parameter int BLK_LSB  = 15,
   parameter bit AAI_EN   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [7:0]    cmd_op,
   input  logic [AW-1:0] cmd_addr,
   input  logic [7:0]    cmd_data,
   input  logic [2:0]    cmd_cycles,
   input  logic          cmd_partial,
   input  logic          op_ack,
   output logic          op_strobe,
   output logic [2:0]    op_kind,
   output logic [AW-1:0] op_addr,
   output logic [7:0]    op_data,
   output logic          wel,
   output logic          busy,
   output logic          aai_active
);
   if (AW < 16 || AW > 24) begin : g_bad_aw
      $error("flash_wr_gate: AW must lie in 16..24");
   end
   if (SECT_LSB < 1 || BLK_LSB <= SECT_LSB || BLK_LSB >= AW) begin : g_bad_lsb
      $error("flash_wr_gate: need 0 < SECT_LSB < BLK_LSB < AW");
   end

   cmd_cls_e      cls;
   logic          complete, ev, ewsr_arm, open_gate;
   logic          acc_prog, acc_first, acc_next, acc_sect, acc_blk, acc_chip, acc_wrsr;
   logic          issue, issue_aai, aai_stop, aai_fin;
   logic [AW-1:0] next_addr, sect_addr, blk_addr;
   op_kind_e      kind_d;
   logic [AW-1:0] addr_d;

   fwg_classify u_cls (
      .op(cmd_op), .cycles(cmd_cycles), .partial(cmd_partial),
      .aai_on(aai_active), .cls(cls), .complete(complete)
   );

   assign ev        = cmd_valid && complete;
   assign open_gate = ev && !busy;
   assign acc_prog  = open_gate && wel && cls == C_PROG;
   assign acc_first = open_gate && wel && cls == C_AAI1 && AAI_EN;
   assign acc_next  = open_gate && cls == C_AAIN;
   assign acc_sect  = open_gate && wel && cls == C_SECT;
   assign acc_blk   = open_gate && wel && cls == C_BLK;
   assign acc_chip  = open_gate && wel && cls == C_CHIP;
   assign acc_wrsr  = open_gate && ewsr_arm && cls == C_WRSR;
   assign issue_aai = acc_first || acc_next;
   assign issue     = acc_prog || issue_aai || acc_sect || acc_blk || acc_chip || acc_wrsr;
   assign aai_stop  = ev && aai_active && cls != C_AAIN && cls != C_RDSR;

   for (genvar b = 0; b < AW; b++) begin : g_region
      if (b >= SECT_LSB) begin : g_s_keep
         assign sect_addr[b] = cmd_addr[b];
      end else begin : g_s_zero
         assign sect_addr[b] = 1'b0;
      end
      if (b >= BLK_LSB) begin : g_b_keep
         assign blk_addr[b] = cmd_addr[b];
      end else begin : g_b_zero
         assign blk_addr[b] = 1'b0;
      end
   end

   if (AAI_EN) begin : g_aai
      fwg_aai_seq #(.AW(AW)) u_aai (
         .clk(clk), .rst_n(rst_n), .start(acc_first), .start_addr(cmd_addr),
         .step(acc_next), .stop(aai_stop), .on(aai_active),
         .next_addr(next_addr), .fin(aai_fin)
      );
   end else begin : g_no_aai
      assign aai_active = 1'b0;
      assign next_addr  = '0;
      assign aai_fin    = 1'b0;
   end

   fwg_guard u_guard (
      .clk(clk), .rst_n(rst_n), .ev(ev), .cls(cls), .issue(issue),
      .issue_aai(issue_aai), .aai_fin(aai_fin), .ack(op_ack),
      .wel(wel), .ewsr_arm(ewsr_arm), .busy(busy)
   );

   always_comb begin
      kind_d = K_PROG;
      addr_d = cmd_addr;
      if (acc_next)      begin kind_d = K_PROG; addr_d = next_addr; end
      else if (acc_sect) begin kind_d = K_SECT; addr_d = sect_addr; end
      else if (acc_blk)  begin kind_d = K_BLK;  addr_d = blk_addr;  end
      else if (acc_chip) begin kind_d = K_CHIP; addr_d = '0;        end
      else if (acc_wrsr) begin kind_d = K_WRSR; addr_d = '0;        end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_strobe <= 1'b0;
         op_kind   <= 3'd0;
         op_addr   <= '0;
         op_data   <= '0;
      end else begin
         op_strobe <= issue;
         if (issue) begin
            op_kind <= kind_d;
            op_addr <= addr_d;
            op_data <= cmd_data;
         end
      end
   end

   assert_gated_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_strobe && op_kind != K_WRSR) |-> $past(wel));
   assert_sector_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_strobe && op_kind == K_SECT) |-> (op_addr[SECT_LSB-1:0] == '0));
   assert_block_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_strobe && op_kind == K_BLK) |-> (op_addr[BLK_LSB-1:0] == '0));
   assert_wrsr_paired_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_strobe && op_kind == K_WRSR) |-> $past(ewsr_arm));
   assert_no_issue_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      op_strobe |-> (busy && !$past(busy)));
   assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op_strobe |=> !op_strobe || $past(issue));
endmodule

// File: tb/flash_wr_gate_bench.sv
module flash_wr_gate_bench;
   localparam int AW = 17;
   localparam logic [AW-1:0] TOPA = {AW{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [7:0]    cmd_op = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic [7:0]    cmd_data = '0;
   logic [2:0]    cmd_cycles = '0;
   logic          cmd_partial = 1'b0;
   logic          op_ack = 1'b0;
   logic          op_strobe, wel, busy, aai_active;
   logic [2:0]    op_kind;
   logic [AW-1:0] op_addr;
   logic [7:0]    op_data;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   flash_wr_gate u_flash_wr_gate (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_cycles(cmd_cycles),
      .cmd_partial(cmd_partial), .op_ack(op_ack), .op_strobe(op_strobe),
      .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
      .wel(wel), .busy(busy), .aai_active(aai_active)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                       input logic [2:0] cyc, input logic part);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
      cmd_cycles = cyc; cmd_partial = part;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic ack_op();
      @(negedge clk);
      op_ack = 1'b1;
      @(negedge clk);
      op_ack = 1'b0;
   endtask

   task automatic expect_op(input string req, input logic [2:0] k,
                            input logic [AW-1:0] a, input logic [7:0] d);
      chk({req, " strobe"}, op_strobe, 1);
      chk({req, " kind"}, op_kind, k);
      chk({req, " addr"}, op_addr, a);
      chk({req, " data"}, op_data, d);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 wel", wel, 0);
      chk("R1 busy", busy, 0);
      chk("R1 aai", aai_active, 0);
      chk("R1 strobe", op_strobe, 0);

      // R3/R10 sweep: every opcode with 5 cycles and latch clear must not strobe
      for (int o = 0; o < 256; o++) begin
         send(o[7:0], 17'h1234, 8'h77, 3'd5, 1'b0);
         chk("R3 sweep strobe", op_strobe, 0);
         chk("R10 sweep wel", wel, 0);
      end
      chk("R10 sweep aai", aai_active, 0);

      // R2 latch set and clear
      send(8'h06, '0, '0, 3'd1, 1'b0);
      chk("R2 set", wel, 1);
      send(8'h04, '0, '0, 3'd1, 1'b0);
      chk("R2 clear", wel, 0);

      // R10 partial program discarded, R4 full program
      send(8'h06, '0, '0, 3'd1, 1'b0);
      send(8'h02, 17'h1234, 8'h5A, 3'd5, 1'b1);
      chk("R10 partial strobe", op_strobe, 0);
      chk("R10 partial wel", wel, 1);
      send(8'h02, 17'h1234, 8'h5A, 3'd5, 1'b0);
      expect_op("R4 program", 3'd0, 17'h1234, 8'h5A);
      chk("R11 busy set", busy, 1);
      send(8'h06, '0, '0, 3'd1, 1'b0);
      send(8'h02, 17'h0042, 8'h11, 3'd5, 1'b0);
      chk("R11 drop while busy", op_strobe, 0);
      ack_op();
      chk("R11 busy release", busy, 0);
      chk("R12 ack clears wel", wel, 0);

      // R5 region masks over an address sweep
      for (int i = 0; i < 12; i++) begin
         logic [AW-1:0] a;
         a = AW'(i * 32'h2F3D + 32'h0ABC);
         send(8'h06, '0, '0, 3'd1, 1'b0);
         send(8'h20, a, 8'h00, 3'd4, 1'b0);
         expect_op("R5 sector", 3'd1, a & ~AW'(32'hFFF), 8'h00);
         ack_op();
         send(8'h06, '0, '0, 3'd1, 1'b0);
         send((i % 2 == 0) ? 8'h52 : 8'hD8, a, 8'h00, 3'd4, 1'b0);
         expect_op("R5 block", 3'd2, a & ~AW'(32'h7FFF), 8'h00);
         ack_op();
      end
      send(8'h06, '0, '0, 3'd1, 1'b0);
      send(8'h60, 17'h1FFFF, 8'h00, 3'd1, 1'b0);
      expect_op("R5 chip 60", 3'd3, '0, 8'h00);
      ack_op();
      send(8'h06, '0, '0, 3'd1, 1'b0);
      send(8'hC7, '0, 8'h00, 3'd1, 1'b0);
      expect_op("R5 chip C7", 3'd3, '0, 8'h00);
      ack_op();

      // R6 status write pairing
      send(8'h50, '0, '0, 3'd1, 1'b0);
      send(8'h01, '0, 8'hA5, 3'd2, 1'b0);
      expect_op("R6 paired", 3'd4, '0, 8'hA5);
      ack_op();
      send(8'h50, '0, '0, 3'd1, 1'b0);
      send(8'h05, '0, '0, 3'd3, 1'b0);
      send(8'h01, '0, 8'h3C, 3'd2, 1'b0);
      chk("R6 read cancels", op_strobe, 0);
      send(8'h01, '0, 8'h3C, 3'd2, 1'b0);
      chk("R6 unpaired", op_strobe, 0);
      send(8'h50, '0, '0, 3'd1, 1'b0);
      send(8'h06, '0, '0, 3'd1, 1'b1);
      send(8'h01, '0, 8'hC3, 3'd2, 1'b0);
      expect_op("R10 partial keeps pair", 3'd4, '0, 8'hC3);
      ack_op();

      // R7/R8/R11/R12 auto-increment stream
      send(8'h06, '0, '0, 3'd1, 1'b0);
      send(8'hAF, 17'h0100, 8'h10, 3'd5, 1'b0);
      expect_op("R7 first", 3'd0, 17'h0100, 8'h10);
      chk("R7 mode on", aai_active, 1);
      send(8'hAF, '0, 8'h20, 3'd2, 1'b0);
      chk("R11 step blocked", op_strobe, 0);
      chk("R11 mode kept", aai_active, 1);
      ack_op();
      chk("R12 aai ack keeps wel", wel, 1);
      for (int s = 1; s <= 4; s++) begin
         send(8'hAF, '0, 8'(8'h20 + s), 3'd2, 1'b0);
         expect_op("R7 step", 3'd0, AW'(32'h0100 + s), 8'(8'h20 + s));
         ack_op();
         send(8'h05, '0, '0, 3'd2, 1'b0);
         chk("R8 status read keeps mode", aai_active, 1);
      end
      send(8'h04, '0, '0, 3'd1, 1'b0);
      chk("R8 wrdi ends", aai_active, 0);
      chk("R8 wrdi wel", wel, 0);

      send(8'h06, '0, '0, 3'd1, 1'b0);
      send(8'hAF, 17'h0200, 8'h01, 3'd5, 1'b0);
      ack_op();
      send(8'h03, 17'h0000, 8'h00, 3'd7, 1'b0);
      chk("R8 read ends", aai_active, 0);
      chk("R8 read clears wel", wel, 0);

      // R9 top address
      send(8'h06, '0, '0, 3'd1, 1'b0);
      send(8'hAF, TOPA - 17'd2, 8'h61, 3'd5, 1'b0);
      expect_op("R9 start", 3'd0, TOPA - 17'd2, 8'h61);
      ack_op();
      send(8'hAF, '0, 8'h62, 3'd2, 1'b0);
      expect_op("R9 mid", 3'd0, TOPA - 17'd1, 8'h62);
      ack_op();
      send(8'hAF, '0, 8'h63, 3'd2, 1'b0);
      expect_op("R9 last", 3'd0, TOPA, 8'h63);
      chk("R9 mode off", aai_active, 0);
      chk("R9 wel off", wel, 0);
      ack_op();
      send(8'hAF, '0, 8'h64, 3'd2, 1'b0);
      chk("R10 short AF outside mode", op_strobe, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule